// File: doc/BRIEF.md
# Two-Port Reservation Arbiter

The arbiter decides, one request at a time, whether a host port (A) or a secondary port (B) may run a cycle on a shared crate bus. It also holds four reservation states: a whole-crate reserve and a single-slot reserve for each port. Request fields arrive already decoded. These fields are the reserve request bits, the target slot, a frame-valid flag and a protocol-error flag. Alongside them come the on-line state, the block-transfer activity and slot, and the Q reply the addressed module returns for a permitted cycle. Frame decoding and bus timing belong to neighbouring blocks.

A requester raises its `*_req` level with its fields and holds them until the arbiter answers with a one-cycle grant or refuse pulse. The controller has four states:
- `ST_IDLE` samples a request.
- `ST_WAIT_A_Q` and `ST_WAIT_B_Q` wait for the Q reply after a grant.
- `ST_RELEASE` spends one cycle after a refusal.

The transitions are:
- IDLE to WAIT_A_Q when A is granted.
- IDLE to WAIT_B_Q when B is granted.
- IDLE to RELEASE on any refusal.
- Either WAIT state to IDLE when `q_valid` arrives.
- RELEASE to IDLE unconditionally.

Port A's reserves lapse after a parameterised number of cycles unless a permitted port A cycle refreshes them.

Top module: `dual_port_rsv_arb`

## Requirements
- R1: After reset all four reserve outputs are 0, both terminated flags (`b_crate_term`, `b_slot_term`) are 1, `agg_fail` is 0, no grant or refuse pulse is active, and both last-slot registers read 0.
- R2: A-crate reserve never coexists with B-crate or B-slot reserve. B-crate reserve never coexists with A-crate or A-slot reserve. When both slot reserves are held, they hold different slots.
- R3: Port A is granted only under all of these conditions:
  - `online` is 1.
  - `a_naf_ok` is 1 and `a_proto_err` is 0.
  - Its slot is not the active block-transfer slot.
  - B's crate reserve is clear, or `a_drop_b_crate` is set.
  - B's slot reserve is clear, or `a_drop_b_slot` is set, or `a_set_crate` is set, or `a_slot` differs from B's reserved slot.
- R4: Port B is granted only under all of these conditions:
  - Both terminated flags are 0.
  - `b_naf_ok` is 1 and `b_proto_err` is 0.
  - A's crate reserve is 0.
  - `b_slot` is not the active block-transfer slot.
  - A's slot reserve is 0, or `b_slot` differs from A's reserved slot.
  - If `b_set_crate` is set, A's crate reserve, A's slot reserve and `bt_active` are all 0.
- R5: A port's reserves change only when `q_valid` and `q_reply` are both 1 after that port's grant. The crate reserve then takes the request's set-crate bit. The slot reserve takes its set-slot bit and records the slot. A port A crate-set that succeeds this way also clears B's slot reserve.
- R6: A port A grant with `a_drop_b_crate` or `a_drop_b_slot` clears the held B reserve at the grant edge, with no Q needed, and sets the matching terminated flag. A port A Q success that clears B's slot reserve also sets `b_slot_term`.
- R7: A port B request while either terminated flag is 1 is refused, and both flags read 0 after that refusal.
- R8: A's reserves clear exactly TIMEOUT_CYCLES cycles after the last port A grant (or after being set from idle), if no further port A grant occurs in between.
- R9: The block-transfer slot is barred to both ports. A port A aggregate request (`a_aggregate`) to that slot sets `agg_fail`. A granted port A request with `a_lam_clear` set clears `agg_fail`.
- R10: When both ports request in the same idle cycle, port A is decided first. Port B, still held, is decided two cycles after A's refusal or one cycle after A's Q reply.
- R11: `a_hits_b` is 1 when `a_slot` equals the last slot port B presented. `b_hits_a` is 1 when `b_slot` equals the last slot port A presented. `a_hits_bt` and `b_hits_bt` are 1 when block transfer is active and the port's slot equals `bt_slot`.
- R12: Each request sampled in ST_IDLE yields exactly one grant or refuse pulse, one cycle later. A refusal is followed by one ST_RELEASE cycle in which requests are not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A request, held until answered |
| a_slot | input | SLOT_W | Port A target slot |
| a_set_crate | input | 1 | Port A asks to hold the crate reserve |
| a_set_slot | input | 1 | Port A asks to hold the slot reserve |
| a_drop_b_crate | input | 1 | Port A asks to end B's crate reserve |
| a_drop_b_slot | input | 1 | Port A asks to end B's slot reserve |
| a_aggregate | input | 1 | Port A request is an aggregate command |
| a_lam_clear | input | 1 | Port A request clears the aggregate failure flag |
| a_naf_ok | input | 1 | Port A function frame valid |
| a_proto_err | input | 1 | Port A protocol error |
| online | input | 1 | Crate on line for port A |
| b_req | input | 1 | Port B request, held until answered |
| b_slot | input | SLOT_W | Port B target slot |
| b_set_crate | input | 1 | Port B asks to hold the crate reserve |
| b_set_slot | input | 1 | Port B asks to hold the slot reserve |
| b_naf_ok | input | 1 | Port B function frame valid |
| b_proto_err | input | 1 | Port B protocol error |
| bt_active | input | 1 | Block transfer running |
| bt_slot | input | SLOT_W | Block-transfer target slot |
| q_valid | input | 1 | Q reply for the granted cycle is present |
| q_reply | input | 1 | Module Q value |
| a_grant | output | 1 | Port A permitted (pulse) |
| a_refuse | output | 1 | Port A refused (pulse) |
| b_grant | output | 1 | Port B permitted (pulse) |
| b_refuse | output | 1 | Port B refused (pulse) |
| rsv_a_crate | output | 1 | Port A holds the crate |
| rsv_a_slot | output | 1 | Port A holds a slot |
| rsv_b_crate | output | 1 | Port B holds the crate |
| rsv_b_slot | output | 1 | Port B holds a slot |
| b_crate_term | output | 1 | B's crate reserve was ended by port A |
| b_slot_term | output | 1 | B's slot reserve was ended by port A |
| agg_fail | output | 1 | Latched aggregate failure |
| a_hits_b | output | 1 | Port A slot equals port B's last slot |
| b_hits_a | output | 1 | Port B slot equals port A's last slot |
| a_hits_bt | output | 1 | Port A slot is the active block-transfer slot |
| b_hits_bt | output | 1 | Port B slot is the active block-transfer slot |

## Verification
A wrong reserve or terminated flag appears on its own output one cycle after the grant or Q edge that produced it. It also shows as a wrong grant or refuse pulse on the very next request from either port. A timer that counts wrongly shows as an A reserve output that drops one or more cycles early or late relative to TIMEOUT_CYCLES. A controller stuck in a wait state shows as a request that never receives a pulse. The bench runs a reference model next to a long mixed request stream over a four-slot configuration. It compares every pulse and every reserve output after every request, so any divergence surfaces within one request.

// File: rtl/dprsv_pkg.sv
package dprsv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_A_Q = 2'd1,
        ST_WAIT_B_Q = 2'd2,
        ST_RELEASE  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/rsv_permit_eval.sv
module rsv_permit_eval #(
    parameter int unsigned SLOT_W = 5
) (
    input  logic              online,
    input  logic [SLOT_W-1:0] a_slot,
    input  logic              a_naf_ok,
    input  logic              a_proto_err,
    input  logic              a_set_crate,
    input  logic              a_drop_b_crate,
    input  logic              a_drop_b_slot,
    input  logic [SLOT_W-1:0] b_slot,
    input  logic              b_naf_ok,
    input  logic              b_proto_err,
    input  logic              b_set_crate,
    input  logic              bt_active,
    input  logic [SLOT_W-1:0] bt_slot,
    input  logic              cra,
    input  logic              nra,
    input  logic              crb,
    input  logic              nrb,
    input  logic              crbt,
    input  logic              nrbt,
    input  logic [SLOT_W-1:0] nra_slot,
    input  logic [SLOT_W-1:0] nrb_slot,
    input  logic [SLOT_W-1:0] last_a,
    input  logic [SLOT_W-1:0] last_b,
    output logic              a_ok,
    output logic              b_ok,
    output logic              a_bt_hit,
    output logic              b_bt_hit,
    output logic              a_hits_b,
    output logic              b_hits_a
);

    logic a_base, a_crb_clear, a_nrb_clear;
    logic b_base, b_nra_clear, b_crate_ok;

    always_comb begin
        a_bt_hit    = bt_active && (a_slot == bt_slot);
        b_bt_hit    = bt_active && (b_slot == bt_slot);
        a_hits_b    = (a_slot == last_b);
        b_hits_a    = (b_slot == last_a);

        a_base      = online && a_naf_ok && !a_proto_err && !a_bt_hit;
        a_crb_clear = !crb || a_drop_b_crate;
        a_nrb_clear = !nrb || a_drop_b_slot || a_set_crate || (a_slot != nrb_slot);
        a_ok        = a_base && a_crb_clear && a_nrb_clear;

        b_base      = !crbt && !nrbt && b_naf_ok && !b_proto_err && !cra && !b_bt_hit;
        b_nra_clear = !nra || (b_slot != nra_slot);
        b_crate_ok  = !b_set_crate || (!cra && !nra && !bt_active);
        b_ok        = b_base && b_nra_clear && b_crate_ok;
    end

endmodule

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer #(
    parameter int unsigned LIMIT = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic restart,
    output logic expire
);

    localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = hold && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!hold || restart || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the age never passes the limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < int'(LIMIT));

    // R8: a permitted port A cycle restarts the age
    p_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/dual_port_rsv_arb.sv
module dual_port_rsv_arb
    import dprsv_pkg::*;
#(
    parameter int unsigned SLOT_W         = 5,
    parameter int unsigned TIMEOUT_CYCLES = 62_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic [SLOT_W-1:0] a_slot,
    input  logic              a_set_crate,
    input  logic              a_set_slot,
    input  logic              a_drop_b_crate,
    input  logic              a_drop_b_slot,
    input  logic              a_aggregate,
    input  logic              a_lam_clear,
    input  logic              a_naf_ok,
    input  logic              a_proto_err,
    input  logic              online,
    input  logic              b_req,
    input  logic [SLOT_W-1:0] b_slot,
    input  logic              b_set_crate,
    input  logic              b_set_slot,
    input  logic              b_naf_ok,
    input  logic              b_proto_err,
    input  logic              bt_active,
    input  logic [SLOT_W-1:0] bt_slot,
    input  logic              q_valid,
    input  logic              q_reply,
    output logic              a_grant,
    output logic              a_refuse,
    output logic              b_grant,
    output logic              b_refuse,
    output logic              rsv_a_crate,
    output logic              rsv_a_slot,
    output logic              rsv_b_crate,
    output logic              rsv_b_slot,
    output logic              b_crate_term,
    output logic              b_slot_term,
    output logic              agg_fail,
    output logic              a_hits_b,
    output logic              b_hits_a,
    output logic              a_hits_bt,
    output logic              b_hits_bt
);

    arb_state_e st, st_nx;

    logic              cra, nra, crb, nrb, crbt, nrbt, agg_q;
    logic [SLOT_W-1:0] nra_slot, nrb_slot, last_a, last_b, p_slot;
    logic              p_crate, p_sslot;
    logic              a_ok, b_ok, a_bt_hit, b_bt_hit;
    logic              take_a, take_b, a_go, b_go, expire;

    rsv_permit_eval #(.SLOT_W(SLOT_W)) u_permit (
        .online         (online),
        .a_slot         (a_slot),
        .a_naf_ok       (a_naf_ok),
        .a_proto_err    (a_proto_err),
        .a_set_crate    (a_set_crate),
        .a_drop_b_crate (a_drop_b_crate),
        .a_drop_b_slot  (a_drop_b_slot),
        .b_slot         (b_slot),
        .b_naf_ok       (b_naf_ok),
        .b_proto_err    (b_proto_err),
        .b_set_crate    (b_set_crate),
        .bt_active      (bt_active),
        .bt_slot        (bt_slot),
        .cra            (cra),
        .nra            (nra),
        .crb            (crb),
        .nrb            (nrb),
        .crbt           (crbt),
        .nrbt           (nrbt),
        .nra_slot       (nra_slot),
        .nrb_slot       (nrb_slot),
        .last_a         (last_a),
        .last_b         (last_b),
        .a_ok           (a_ok),
        .b_ok           (b_ok),
        .a_bt_hit       (a_bt_hit),
        .b_bt_hit       (b_bt_hit),
        .a_hits_b       (a_hits_b),
        .b_hits_a       (b_hits_a)
    );

    assign take_a = (st == ST_IDLE) && a_req;
    assign take_b = (st == ST_IDLE) && b_req && !a_req;
    assign a_go   = take_a && a_ok;
    assign b_go   = take_b && b_ok;

    rsv_hold_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (cra || nra),
        .restart (a_go),
        .expire  (expire)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (a_go)                 st_nx = ST_WAIT_A_Q;
                else if (b_go)            st_nx = ST_WAIT_B_Q;
                else if (take_a || take_b) st_nx = ST_RELEASE;
            end
            ST_WAIT_A_Q: if (q_valid) st_nx = ST_IDLE;
            ST_WAIT_B_Q: if (q_valid) st_nx = ST_IDLE;
            ST_RELEASE:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_grant  <= 1'b0;
            a_refuse <= 1'b0;
            b_grant  <= 1'b0;
            b_refuse <= 1'b0;
            cra      <= 1'b0;
            nra      <= 1'b0;
            crb      <= 1'b0;
            nrb      <= 1'b0;
            crbt     <= 1'b1;
            nrbt     <= 1'b1;
            agg_q    <= 1'b0;
            nra_slot <= '0;
            nrb_slot <= '0;
            last_a   <= '0;
            last_b   <= '0;
            p_slot   <= '0;
            p_crate  <= 1'b0;
            p_sslot  <= 1'b0;
        end else begin
            a_grant  <= a_go;
            a_refuse <= take_a && !a_ok;
            b_grant  <= b_go;
            b_refuse <= take_b && !b_ok;

            if (expire) begin
                cra <= 1'b0;
                nra <= 1'b0;
            end

            if (take_a) begin
                last_a <= a_slot;
                if (a_aggregate && a_bt_hit) agg_q <= 1'b1;
                if (a_ok) begin
                    p_crate <= a_set_crate;
                    p_sslot <= a_set_slot;
                    p_slot  <= a_slot;
                    if (a_lam_clear) agg_q <= 1'b0;
                    if (a_drop_b_crate && crb) begin
                        crb  <= 1'b0;
                        crbt <= 1'b1;
                    end
                    if (a_drop_b_slot && nrb) begin
                        nrb  <= 1'b0;
                        nrbt <= 1'b1;
                    end
                end
            end

            if (take_b) begin
                last_b <= b_slot;
                if (crbt || nrbt) begin
                    crbt <= 1'b0;
                    nrbt <= 1'b0;
                end
                if (b_ok) begin
                    p_crate <= b_set_crate;
                    p_sslot <= b_set_slot;
                    p_slot  <= b_slot;
                end
            end

            if (st == ST_WAIT_A_Q && q_valid && q_reply) begin
                cra      <= p_crate;
                nra      <= p_sslot;
                nra_slot <= p_slot;
                if (p_crate && nrb) begin
                    nrb  <= 1'b0;
                    nrbt <= 1'b1;
                end
            end

            if (st == ST_WAIT_B_Q && q_valid && q_reply) begin
                crb      <= p_crate;
                nrb      <= p_sslot;
                nrb_slot <= p_slot;
            end
        end
    end

    assign rsv_a_crate  = cra;
    assign rsv_a_slot   = nra;
    assign rsv_b_crate  = crb;
    assign rsv_b_slot   = nrb;
    assign b_crate_term = crbt;
    assign b_slot_term  = nrbt;
    assign agg_fail     = agg_q;
    assign a_hits_bt    = a_bt_hit;
    assign b_hits_bt    = b_bt_hit;

    // R2: crate reserves exclude the other port's reserves
    p_crate_a_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cra |-> (!crb && !nrb));
    p_crate_b_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        crb |-> (!cra && !nra));
    // R2: two slot reserves never share a slot
    p_slot_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nra && nrb) |-> (nra_slot != nrb_slot));

    // R4: a B grant never lands while A holds the crate or a flag is up
    p_b_grant_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_grant |-> (!crbt && !nrbt && !cra));

    // R5: B reserves hold still while the Q reply is pending
    p_q_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_B_Q && !q_valid) |=> $stable({crb, nrb}));

    // R7: a refusal under a raised flag lowers both flags
    p_term_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_refuse && $past(crbt || nrbt)) |-> (!crbt && !nrbt));

    // R9: the block-transfer slot is never granted to port A
    p_bt_barred_r9: assert property (@(posedge clk) disable iff (!rst_n)
        a_grant |-> !$past(a_bt_hit));

    // R10: at most one decision per cycle
    p_one_decision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_grant, a_refuse, b_grant, b_refuse}));

    // R12: the release cycle always returns to idle
    p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RELEASE) |=> (st == ST_IDLE));

endmodule

// File: tb/dual_port_rsv_arb_tb.sv
module dual_port_rsv_arb_tb;

    localparam int unsigned SW = 2;
    localparam int unsigned TO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_req = 0, a_set_crate = 0, a_set_slot = 0, a_drop_b_crate = 0;
    logic          a_drop_b_slot = 0, a_aggregate = 0, a_lam_clear = 0, a_naf_ok = 1;
    logic          a_proto_err = 0, online = 1;
    logic [SW-1:0] a_slot = '0, b_slot = '0, bt_slot = '0;
    logic          b_req = 0, b_set_crate = 0, b_set_slot = 0, b_naf_ok = 1, b_proto_err = 0;
    logic          bt_active = 0, q_valid = 0, q_reply = 0;
    logic          a_grant, a_refuse, b_grant, b_refuse;
    logic          rsv_a_crate, rsv_a_slot, rsv_b_crate, rsv_b_slot;
    logic          b_crate_term, b_slot_term, agg_fail;
    logic          a_hits_b, b_hits_a, a_hits_bt, b_hits_bt;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit            m_cra = 0, m_nra = 0, m_crb = 0, m_nrb = 0;
    bit            m_crbt = 1, m_nrbt = 1, m_agg = 0;
    logic [SW-1:0] m_nra_slot = '0, m_nrb_slot = '0, m_last_a = '0, m_last_b = '0;
    int            m_age = 0;

    always #4 clk = ~clk;

    dual_port_rsv_arb #(.SLOT_W(SW), .TIMEOUT_CYCLES(TO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_slot(a_slot), .a_set_crate(a_set_crate), .a_set_slot(a_set_slot),
        .a_drop_b_crate(a_drop_b_crate), .a_drop_b_slot(a_drop_b_slot),
        .a_aggregate(a_aggregate), .a_lam_clear(a_lam_clear), .a_naf_ok(a_naf_ok),
        .a_proto_err(a_proto_err), .online(online),
        .b_req(b_req), .b_slot(b_slot), .b_set_crate(b_set_crate), .b_set_slot(b_set_slot),
        .b_naf_ok(b_naf_ok), .b_proto_err(b_proto_err),
        .bt_active(bt_active), .bt_slot(bt_slot), .q_valid(q_valid), .q_reply(q_reply),
        .a_grant(a_grant), .a_refuse(a_refuse), .b_grant(b_grant), .b_refuse(b_refuse),
        .rsv_a_crate(rsv_a_crate), .rsv_a_slot(rsv_a_slot), .rsv_b_crate(rsv_b_crate),
        .rsv_b_slot(rsv_b_slot), .b_crate_term(b_crate_term), .b_slot_term(b_slot_term),
        .agg_fail(agg_fail), .a_hits_b(a_hits_b), .b_hits_a(b_hits_a),
        .a_hits_bt(a_hits_bt), .b_hits_bt(b_hits_bt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit coin(input int unsigned n);
        return ($urandom % n) == 0;
    endfunction

    // one clock: age the model's A reserves at the edge, return at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst_n) begin
            if (m_cra || m_nra) begin
                m_age++;
                if (m_age == int'(TO)) begin
                    m_cra = 0;
                    m_nra = 0;
                    m_age = 0;
                end
            end else begin
                m_age = 0;
            end
        end
        @(negedge clk);
    endtask

    function automatic bit exp_a();
        bit hit;
        hit = bt_active && (a_slot == bt_slot);
        return online && a_naf_ok && !a_proto_err && !hit
            && (!m_crb || a_drop_b_crate)
            && (!m_nrb || a_drop_b_slot || a_set_crate || (a_slot != m_nrb_slot));
    endfunction

    function automatic bit exp_b();
        bit hit;
        hit = bt_active && (b_slot == bt_slot);
        return !m_crbt && !m_nrbt && b_naf_ok && !b_proto_err && !m_cra && !hit
            && (!m_nra || (b_slot != m_nra_slot))
            && (!b_set_crate || (!m_cra && !m_nra && !bt_active));
    endfunction

    task automatic chk_hits();
        chk("R11 a_hits_b", int'(a_hits_b), int'(a_slot == m_last_b));
        chk("R11 b_hits_a", int'(b_hits_a), int'(b_slot == m_last_a));
        chk("R11 a_hits_bt", int'(a_hits_bt), int'(bt_active && (a_slot == bt_slot)));
        chk("R11 b_hits_bt", int'(b_hits_bt), int'(bt_active && (b_slot == bt_slot)));
    endtask

    task automatic chk_state();
        chk("R5 rsv_a_crate", int'(rsv_a_crate), int'(m_cra));
        chk("R5 rsv_a_slot", int'(rsv_a_slot), int'(m_nra));
        chk("R5 rsv_b_crate", int'(rsv_b_crate), int'(m_crb));
        chk("R5 rsv_b_slot", int'(rsv_b_slot), int'(m_nrb));
        chk("R6 b_crate_term", int'(b_crate_term), int'(m_crbt));
        chk("R6 b_slot_term", int'(b_slot_term), int'(m_nrbt));
        chk("R9 agg_fail", int'(agg_fail), int'(m_agg));
    endtask

    task automatic run_a(input bit qv);
        bit e, hit;
        e   = exp_a();
        hit = bt_active && (a_slot == bt_slot);
        a_req = 1;
        #1;
        chk_hits();
        tick();
        chk("R3 a_grant", int'(a_grant), int'(e));
        chk("R12 a_refuse", int'(a_refuse), int'(!e));
        m_last_a = a_slot;
        if (a_aggregate && hit) m_agg = 1;
        if (e) begin
            m_age = 0;
            if (a_lam_clear) m_agg = 0;
            if (a_drop_b_crate && m_crb) begin m_crb = 0; m_crbt = 1; end
            if (a_drop_b_slot && m_nrb) begin m_nrb = 0; m_nrbt = 1; end
        end
        a_req = 0;
        if (e) begin
            q_valid = 1;
            q_reply = qv;
            tick();
            q_valid = 0;
            if (qv) begin
                m_cra = a_set_crate;
                m_nra = a_set_slot;
                m_nra_slot = a_slot;
                if (a_set_crate && m_nrb) begin m_nrb = 0; m_nrbt = 1; end
            end
        end else begin
            tick();
        end
        chk_state();
    endtask

    task automatic run_b(input bit qv);
        bit e;
        e = exp_b();
        b_req = 1;
        #1;
        chk_hits();
        tick();
        chk("R4 b_grant", int'(b_grant), int'(e));
        chk("R12 b_refuse", int'(b_refuse), int'(!e));
        m_last_b = b_slot;
        if (m_crbt || m_nrbt) begin m_crbt = 0; m_nrbt = 0; end
        b_req = 0;
        if (e) begin
            q_valid = 1;
            q_reply = qv;
            tick();
            q_valid = 0;
            if (qv) begin
                m_crb = b_set_crate;
                m_nrb = b_set_slot;
                m_nrb_slot = b_slot;
            end
        end else begin
            tick();
        end
        chk_state();
    endtask

    task automatic clear_a_fields();
        a_set_crate = 0; a_set_slot = 0; a_drop_b_crate = 0; a_drop_b_slot = 0;
        a_aggregate = 0; a_lam_clear = 0; a_naf_ok = 1; a_proto_err = 0; online = 1;
    endtask

    task automatic clear_b_fields();
        b_set_crate = 0; b_set_slot = 0; b_naf_ok = 1; b_proto_err = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 grants", int'({a_grant, a_refuse, b_grant, b_refuse}), 0);
        chk("R1 reserves", int'({rsv_a_crate, rsv_a_slot, rsv_b_crate, rsv_b_slot}), 0);
        chk("R1 term flags", int'({b_crate_term, b_slot_term}), 3);
        chk("R1 agg_fail", int'(agg_fail), 0);
        chk("R1 last slots", int'({a_hits_b, b_hits_a}), 3);
        tick();

        // R7: first B request is refused, flags drop
        clear_a_fields(); clear_b_fields();
        b_slot = 2'd1; b_set_slot = 1;
        run_b(1);
        chk("R7 refused", int'(rsv_b_slot), 0);
        chk("R7 flags low", int'({b_crate_term, b_slot_term}), 0);
        // R4/R5: B now gets slot 1
        run_b(1);
        chk("R5 b slot held", int'(rsv_b_slot), 1);
        // R3: A to slot 1 without drop is refused
        a_slot = 2'd1;
        run_a(1);
        chk("R3 blocked by b slot", int'(rsv_a_crate), 0);
        // R6: A drops B's slot and takes the crate
        a_drop_b_slot = 1; a_set_crate = 1;
        run_a(1);
        chk("R6 b slot gone", int'(rsv_b_slot), 0);
        chk("R6 slot term", int'(b_slot_term), 1);
        chk("R5 a crate held", int'(rsv_a_crate), 1);
        // R8: timeout
        clear_a_fields();
        repeat (TO - 1) tick();
        chk("R8 still held", int'(rsv_a_crate), 1);
        tick();
        chk("R8 lapsed", int'(rsv_a_crate), 0);
        chk("R8 model agrees", int'(m_cra), 0);

        // R10: simultaneous requests, A first
        online = 0; a_slot = 2'd0; b_slot = 2'd2; clear_b_fields();
        a_req = 1; b_req = 1;
        tick();
        chk("R10 a decided", int'(a_refuse), 1);
        chk("R10 b waits", int'({b_grant, b_refuse}), 0);
        m_last_a = a_slot;
        a_req = 0;
        tick();
        chk("R10 b waits release", int'({b_grant, b_refuse}), 0);
        tick();
        chk("R10 b refused (flag)", int'(b_refuse), 1);
        m_last_b = b_slot; m_crbt = 0; m_nrbt = 0;
        b_req = 0;
        tick();
        chk_state();

        // R9: aggregate into the block-transfer slot
        clear_a_fields();
        bt_active = 1; bt_slot = 2'd2; a_slot = 2'd2; a_aggregate = 1;
        run_a(1);
        chk("R9 agg set", int'(agg_fail), 1);
        clear_a_fields();
        a_slot = 2'd3; a_lam_clear = 1;
        run_a(0);
        chk("R9 agg cleared", int'(agg_fail), 0);
        bt_active = 0;

        // mixed sweep against the model
        for (int i = 0; i < 1500; i++) begin
            if (coin(8)) begin bt_active = coin(2); bt_slot = SW'($urandom); end
            if (coin(2)) begin
                a_slot = SW'($urandom);
                a_set_crate = coin(3); a_set_slot = coin(2);
                a_drop_b_crate = coin(4); a_drop_b_slot = coin(4);
                a_aggregate = coin(4); a_lam_clear = coin(4);
                a_naf_ok = !coin(10); a_proto_err = coin(10); online = !coin(10);
                b_slot = SW'($urandom);
                run_a(!coin(4));
            end else begin
                b_slot = SW'($urandom);
                b_set_crate = coin(3); b_set_slot = coin(2);
                b_naf_ok = !coin(10); b_proto_err = coin(10);
                a_slot = SW'($urandom);
                run_b(!coin(4));
            end
            if (coin(3)) repeat ($urandom % 12) tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

endmodule